// File: doc/BRIEF.md
# Write-Completion Acknowledge Polling Sequencer

This block sits above a bit-level serial bus engine and works out when a serial memory has finished its internal write cycle. While the memory is programming, it does not acknowledge its own address. The sequencer uses that as a busy test. It sends a START condition and then the device address with the direction bit cleared. If the address is not acknowledged, it sends another START and the address again. It stops after a parameterised number of attempts.

Once the address is acknowledged, there are two ways to finish. If the requester says the next operation is a write, the sequencer sends the byte address in the same transaction and leaves the bus open, so the requester can go straight on with the data. If the next operation is not a write, the sequencer sends STOP. In both cases it pulses `done` and drops `busy`, and a two-bit status code with the attempt count tells the requester what happened.

The engine interface is request/complete. The sequencer raises one single-cycle request (start, stop or send-byte). It then waits until the engine pulses `eng_done`. For a send, `eng_nack` is valid in the same cycle as `eng_done`.

Top module: `ackpoll_seq`

## Requirements
- R1: A command on `cmd_valid` is taken only while `busy` is low. `busy` is high from the cycle after a command is taken until the cycle after `done`. A `cmd_valid` raised while busy is ignored, and its address never appears on the bus.
- R2: Each poll attempt is one start request followed by one send request. The byte sent is the device address in bits 7:1 with bit 0 (write direction) equal to 0.
- R3: When the address is not acknowledged and the attempt limit has not been reached, the next request is another start, with no stop in between.
- R4: When the address is acknowledged and the command marked the next operation as a write, the byte address is sent next and no stop is issued. Status is then 1 (bus held for write).
- R5: When the address is acknowledged and the next operation is not a write, a stop is issued. Status is then 0 (device ready, bus released).
- R6: After `MAX_POLLS` unacknowledged address attempts, a stop is issued and status is 2 (timeout). `attempts` then equals `MAX_POLLS` and never exceeds it.
- R7: If the byte address is not acknowledged, a stop is issued and status is 3 (byte address refused).
- R8: `done` is a one-cycle pulse at the end of every command. `status` and `attempts` keep their values until the next command is taken.
- R9: After reset, `busy`, `done`, every engine request, `status` and `attempts` are all 0.
- R10: Engine requests are single-cycle pulses, at most one at a time, and none is raised while idle. A new request follows only after `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start a polling command (taken when idle) |
| cmd_dev | input | DEV_W | Device address of the memory |
| cmd_next_write | input | 1 | Next operation is a write: keep the bus and send the byte address |
| cmd_byte_addr | input | BYTE_W | Byte address sent when the next operation is a write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ready/stopped, 1 held for write, 2 timeout, 3 byte address refused |
| attempts | output | CNT_W | Address attempts made by the last command |
| eng_start | output | 1 | Request a START condition |
| eng_stop | output | 1 | Request a STOP condition |
| eng_send | output | 1 | Request sending `eng_byte` |
| eng_byte | output | BYTE_W | Byte to send |
| eng_done | input | 1 | Engine finished the last request |
| eng_nack | input | 1 | Sent byte was not acknowledged (valid with `eng_done`) |

## Verification
The bench builds the block with `MAX_POLLS` = 4, so one command can reach the timeout within a few dozen cycles. The same setting puts the boundary cases next to each other: a device that is busy for three attempts and answers on the last permitted one, and a device that stays busy for four or more attempts. A model engine answers each request three cycles later and refuses a chosen number of address phases. With these values, repeated starts, the held-bus handoff, a refused byte address and a command ignored in mid-poll all show up at the ports.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

  typedef enum logic [3:0] {
    PS_IDLE, PS_ISS_START, PS_W_START, PS_ISS_ADDR, PS_W_ADDR,
    PS_ISS_BADDR, PS_W_BADDR, PS_ISS_STOP, PS_W_STOP, PS_FIN
  } poll_state_t;

  typedef enum logic [1:0] {
    RES_CLEAR     = 2'd0,
    RES_HELD      = 2'd1,
    RES_TIMEOUT   = 2'd2,
    RES_ADDR_NACK = 2'd3
  } poll_res_t;

endpackage

// File: rtl/ackpoll_cnt.sv
module ackpoll_cnt #(
  parameter int MAX_POLLS = 255,
  parameter int CNT_W     = $clog2(MAX_POLLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_POLLS);

  logic [CNT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    count_en = clr | (inc & (count != LIMIT));
    count_d  = clr ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_d;
  end

  assign at_limit = (count == LIMIT);

endmodule

// File: rtl/ackpoll_fsm.sv
module ackpoll_fsm
  import ackpoll_pkg::*;
#(
  parameter int DEV_W  = 7,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [DEV_W-1:0]  cmd_dev,
  input  logic              cmd_next_write,
  input  logic [BYTE_W-1:0] cmd_byte_addr,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic              at_limit,
  output logic              accept,
  output logic              addr_issue,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic              eng_start,
  output logic              eng_stop,
  output logic              eng_send,
  output logic [BYTE_W-1:0] eng_byte
);

  poll_state_t       state, state_d;
  poll_res_t         res_q, res_d;
  logic              res_en;
  logic [DEV_W-1:0]  dev_q;
  logic [BYTE_W-1:0] baddr_q;
  logic              nw_q;

  assign accept = (state == PS_IDLE) & cmd_valid;

  always_comb begin
    state_d = state;
    res_d   = res_q;
    res_en  = 1'b0;
    unique case (state)
      PS_IDLE: if (cmd_valid) begin
        state_d = PS_ISS_START;
        res_d   = RES_CLEAR;
        res_en  = 1'b1;
      end
      PS_ISS_START: state_d = PS_W_START;
      PS_W_START:   if (eng_done) state_d = PS_ISS_ADDR;
      PS_ISS_ADDR:  state_d = PS_W_ADDR;
      PS_W_ADDR: if (eng_done) begin
        if (!eng_nack) begin
          state_d = nw_q ? PS_ISS_BADDR : PS_ISS_STOP;
        end else if (at_limit) begin
          state_d = PS_ISS_STOP;
          res_d   = RES_TIMEOUT;
          res_en  = 1'b1;
        end else begin
          state_d = PS_ISS_START;
        end
      end
      PS_ISS_BADDR: state_d = PS_W_BADDR;
      PS_W_BADDR: if (eng_done) begin
        state_d = eng_nack ? PS_ISS_STOP : PS_FIN;
        res_d   = eng_nack ? RES_ADDR_NACK : RES_HELD;
        res_en  = 1'b1;
      end
      PS_ISS_STOP: state_d = PS_W_STOP;
      PS_W_STOP:   if (eng_done) state_d = PS_FIN;
      PS_FIN:      state_d = PS_IDLE;
      default:     state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_IDLE;
    else        state <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= RES_CLEAR;
    else if (res_en) res_q <= res_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q   <= '0;
      baddr_q <= '0;
      nw_q    <= 1'b0;
    end else if (accept) begin
      dev_q   <= cmd_dev;
      baddr_q <= cmd_byte_addr;
      nw_q    <= cmd_next_write;
    end
  end

  assign addr_issue = (state == PS_ISS_ADDR);
  assign busy       = (state != PS_IDLE);
  assign done       = (state == PS_FIN);
  assign status     = res_q;
  assign eng_start  = (state == PS_ISS_START);
  assign eng_stop   = (state == PS_ISS_STOP);
  assign eng_send   = addr_issue | (state == PS_ISS_BADDR);
  assign eng_byte   = (state == PS_ISS_BADDR) ? baddr_q
                                              : BYTE_W'({dev_q, 1'b0});

endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq #(
  parameter int DEV_W     = 7,
  parameter int BYTE_W    = 8,
  parameter int MAX_POLLS = 255,
  parameter int CNT_W     = $clog2(MAX_POLLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [DEV_W-1:0]  cmd_dev,
  input  logic              cmd_next_write,
  input  logic [BYTE_W-1:0] cmd_byte_addr,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [CNT_W-1:0]  attempts,
  output logic              eng_start,
  output logic              eng_stop,
  output logic              eng_send,
  output logic [BYTE_W-1:0] eng_byte,
  input  logic              eng_done,
  input  logic              eng_nack
);

  logic accept, addr_issue, at_limit;

  ackpoll_fsm #(.DEV_W(DEV_W), .BYTE_W(BYTE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_dev(cmd_dev),
    .cmd_next_write(cmd_next_write), .cmd_byte_addr(cmd_byte_addr),
    .eng_done(eng_done), .eng_nack(eng_nack), .at_limit(at_limit),
    .accept(accept), .addr_issue(addr_issue),
    .busy(busy), .done(done), .status(status),
    .eng_start(eng_start), .eng_stop(eng_stop),
    .eng_send(eng_send), .eng_byte(eng_byte)
  );

  ackpoll_cnt #(.MAX_POLLS(MAX_POLLS), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr(accept), .inc(addr_issue),
    .count(attempts), .at_limit(at_limit)
  );

endmodule

// File: rtl/ackpoll_chk.sv
module ackpoll_chk #(
  parameter int MAX_POLLS = 255,
  parameter int CNT_W     = $clog2(MAX_POLLS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic [1:0]       status,
  input logic [CNT_W-1:0] attempts,
  input logic             eng_start,
  input logic             eng_stop,
  input logic             eng_send
);

  logic any_req;
  assign any_req = eng_start | eng_stop | eng_send;

  assert_one_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_start, eng_stop, eng_send}));

  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> !any_req);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !any_req);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  assert_attempt_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    attempts <= CNT_W'(MAX_POLLS));

  assert_timeout_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd2) |-> (attempts == CNT_W'(MAX_POLLS)));

endmodule

bind ackpoll_seq ackpoll_chk #(.MAX_POLLS(MAX_POLLS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .status(status),
  .attempts(attempts), .eng_start(eng_start), .eng_stop(eng_stop),
  .eng_send(eng_send)
);

// File: tb/sim_ackpoll_seq.sv
`timescale 1ns/1ps
module sim_ackpoll_seq;

  localparam int MAXP  = 4;
  localparam int CW    = $clog2(MAXP + 1);
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cmd_valid = 1'b0;
  logic [6:0] cmd_dev = '0;
  logic       cmd_nw = 1'b0;
  logic [7:0] cmd_ba = '0;
  logic busy, done, eng_start, eng_stop, eng_send;
  logic [1:0] status;
  logic [CW-1:0] attempts;
  logic [7:0] eng_byte;
  logic eng_done = 1'b0, eng_nack = 1'b0;

  ackpoll_seq #(.MAX_POLLS(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dev(cmd_dev),
    .cmd_next_write(cmd_nw), .cmd_byte_addr(cmd_ba),
    .busy(busy), .done(done), .status(status), .attempts(attempts),
    .eng_start(eng_start), .eng_stop(eng_stop), .eng_send(eng_send),
    .eng_byte(eng_byte), .eng_done(eng_done), .eng_nack(eng_nack)
  );

  // model engine and memory
  logic       clr_req = 1'b0;
  int         busy_polls = 0;
  logic       refuse_ba = 1'b0;
  logic [6:0] exp_dev = '0;
  int pend = 0, starts = 0, stops = 0, sends = 0, addr_seen = 0, bad_addr = 0;
  int dones = 0, stop_after_start = 0;
  logic addr_phase = 1'b0, nack_next = 1'b0, last_was_start = 1'b0;
  logic [7:0] last_byte = '0;

  always @(posedge clk) begin
    if (clr_req) begin
      starts <= 0; stops <= 0; sends <= 0; addr_seen <= 0; bad_addr <= 0;
      dones <= 0; stop_after_start <= 0; pend <= 0; eng_done <= 1'b0;
      addr_phase <= 1'b0; last_was_start <= 1'b0;
    end else begin
      if (done) dones <= dones + 1;
      eng_done <= (pend == 1);
      eng_nack <= (pend == 1) ? nack_next : 1'b0;
      if (pend > 0) pend <= pend - 1;
      if (eng_start) begin
        starts <= starts + 1; pend <= LAT; nack_next <= 1'b0;
        addr_phase <= 1'b1; last_was_start <= 1'b1;
      end
      if (eng_stop) begin
        stops <= stops + 1; pend <= LAT; nack_next <= 1'b0;
        last_was_start <= 1'b0;
      end
      if (eng_send) begin
        sends <= sends + 1; pend <= LAT; last_byte <= eng_byte;
        if (addr_phase) begin
          addr_seen <= addr_seen + 1;
          if (eng_byte != {exp_dev, 1'b0}) bad_addr <= bad_addr + 1;
          nack_next <= (addr_seen < busy_polls);
          if (!last_was_start) bad_addr <= bad_addr + 1;
        end else begin
          nack_next <= refuse_ba;
        end
        addr_phase <= 1'b0; last_was_start <= 1'b0;
      end
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [6:0] dev, input logic nw,
                         input logic [7:0] ba, input int bp, input logic rba,
                         input logic intrude);
    @(negedge clk);
    clr_req = 1'b1; busy_polls = bp; refuse_ba = rba; exp_dev = dev;
    @(negedge clk);
    clr_req = 1'b0;
    cmd_valid = 1'b1; cmd_dev = dev; cmd_nw = nw; cmd_ba = ba;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R1 busy after accept", int'(busy), 1);
    for (int i = 0; i < 2000; i++) begin
      if (done) break;
      if (intrude && i == 6) begin
        cmd_valid = 1'b1; cmd_dev = ~dev; cmd_nw = ~nw;
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk("R8 done reached (watchdog)", int'(done), 1);
  endtask

  typedef struct packed {
    logic [6:0] dev;
    logic       nw;
    logic [3:0] bp;
    logic [1:0] st;
    logic [3:0] att;
    logic [3:0] nstart;
    logic [1:0] nstop;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{7'h50, 1'b0, 4'd0, 2'd0, 4'd1, 4'd1, 2'd1},  // R5 ready at once
    '{7'h51, 1'b1, 4'd2, 2'd1, 4'd3, 4'd3, 2'd0},  // R3 R4 held for write
    '{7'h52, 1'b0, 4'd3, 2'd0, 4'd4, 4'd4, 2'd1},  // R6 last permitted try
    '{7'h53, 1'b1, 4'd4, 2'd2, 4'd4, 4'd4, 2'd1},  // R6 timeout
    '{7'h2A, 1'b0, 4'd9, 2'd2, 4'd4, 4'd4, 2'd1},  // R6 long busy
    '{7'h7F, 1'b1, 4'd0, 2'd1, 4'd1, 4'd1, 2'd0}   // R2 R4 all-ones addr
  };

  initial begin
    #30;
    chk("R9 busy in reset", int'(busy), 0);
    chk("R9 requests in reset", int'(eng_start | eng_stop | eng_send), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R9 done after reset", int'(done), 0);
    chk("R9 status after reset", int'(status), 0);
    chk("R9 attempts after reset", int'(attempts), 0);

    foreach (VEC[k]) begin
      run_cmd(VEC[k].dev, VEC[k].nw, 8'hC0 + 8'(k), int'(VEC[k].bp), 1'b0, 1'b0);
      chk("R4 R5 R6 R7 status", int'(status), int'(VEC[k].st));
      chk("R6 attempts", int'(attempts), int'(VEC[k].att));
      chk("R2 R3 start count", starts, int'(VEC[k].nstart));
      chk("R3 R5 stop count", stops, int'(VEC[k].nstop));
      chk("R2 address byte and order", bad_addr, 0);
      if (VEC[k].st == 2'd1) chk("R4 byte address sent", int'(last_byte), int'(8'hC0 + 8'(k)));
      @(negedge clk);
      chk("R8 done single pulse", int'(done), 0);
      chk("R1 idle after done", int'(busy), 0);
      chk("R8 status held", int'(status), int'(VEC[k].st));
    end

    // R7 byte address refused
    run_cmd(7'h44, 1'b1, 8'h3C, 1, 1'b1, 1'b0);
    chk("R7 status", int'(status), 3);
    chk("R7 stop issued", stops, 1);
    chk("R7 sends", sends, 3);

    // R1 command raised mid-poll is ignored
    run_cmd(7'h31, 1'b0, 8'h00, 3, 1'b0, 1'b1);
    chk("R1 intruder address absent", bad_addr, 0);
    chk("R1 status of original", int'(status), 0);
    chk("R1 attempts of original", attempts, 4);
    repeat (10) @(negedge clk);
    chk("R1 intruder not started later", starts, 4);
    chk("R10 single completion", dones, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule